// File: doc/BRIEF.md
# Division Operand Prescale Fixup

This block conditions a single-precision (binary32) numerator and denominator before they enter an iterative, reciprocal-based division datapath. Operands that produce a special quotient are sorted out first. NaN, infinity and zero operands are replaced by substitute values, so that the downstream iterations produce the correct special result on their own. The exception flags that the division would raise are reported at the same time.

Ordinary operands are instead scaled by powers of two. This keeps the intermediate values of the iterations clear of overflow and underflow. An 8-bit adjust code tells the back end which correction to apply to the final quotient, and a proceed flag marks the operands that need the iterations at all.

Each operand pair arrives with a one-cycle valid strobe. The results appear, registered, two clock cycles later with a one-cycle done strobe.

Top module: `divpre_fixup`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. Operands presented while `in_valid` is low are ignored. All data outputs hold their previous values in cycles where `out_valid` is low.
- R2: If either operand is a NaN (exponent 0xFF, mantissa nonzero), the numerator, denominator and seed outputs are all 0xFFFFFFFF. Invalid is raised when any NaN operand has mantissa bit 22 clear.
- R3: Infinity divided by infinity, and zero divided by zero, give 0xFFFFFFFF on all three value outputs and raise invalid.
- R4: A non-NaN numerator divided by a zero denominator gives a numerator of infinity, with its sign equal to the XOR of the operand signs. Denominator and seed are 1.0 (0x3F800000) and divide-by-zero is raised. This includes an infinite numerator.
- R5: A finite or zero numerator divided by infinity, and zero divided by a finite value, give a zero numerator signed by the sign XOR. Infinity divided by a finite nonzero value gives an infinite numerator signed the same way. In all these cases denominator and seed are 1.0 and no flag is raised.
- R6: Special cases are resolved in this priority order: NaN, then infinity/infinity or zero/zero, then zero denominator, then infinite denominator, then zero numerator, then infinite numerator.
- R7: For ordinary operands, with the biased difference D = Enum − Eden + 127: if D ≤ 23, the adjust code is 0x80, the numerator is scaled by 2^64 and the denominator by 2^-64.
- R8: Otherwise, if D > 230, the adjust code is 0x40, the numerator is scaled by 2^-32 and the denominator by 2^32.
- R9: Otherwise the adjust code is 0x00. Both operands are scaled by 2^64 if Enum ≤ 25. Failing that, both are scaled by 2^32 if Eden ≤ 1. Failing that, both are scaled by 2^-32 if Eden > 252. Otherwise both pass unchanged.
- R10: Ordinary operands give seed 0, proceed 1 and no flags. Every special case gives proceed 0 and adjust code 0x00. Flags are encoded as bit 0 invalid and bit 1 divide-by-zero.
- R11: A subnormal operand counts as exponent 1 in R7 to R9. When such an operand is scaled, it is normalised, so the scaled value is exact.
- R12: After reset, and until the first result, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair strobe |
| num_in | input | 32 | Numerator, binary32 |
| den_in | input | 32 | Denominator, binary32 |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| num_out | output | 32 | Fixed-up numerator |
| den_out | output | 32 | Fixed-up denominator |
| seed_out | output | 32 | Seed value for the iterations |
| adj_code | output | 8 | Quotient post-adjust code |
| proceed | output | 1 | High when the iterations must run |
| exc_flags | output | 2 | Bit 0 invalid, bit 1 divide-by-zero |

## Verification
Several properties are checked on every cycle:

- the two-cycle latency;
- that outputs hold between results;
- that the adjust code stays within its three legal values, and is zero whenever proceed is low;
- that a proceeding result carries a zero seed and no flags;
- that an invalid result carries the all-ones NaN pattern;
- that a divide-by-zero result carries an infinite numerator.

Other behaviours show only in the bench's scenarios. These are the exact scaled values, the exponent-difference thresholds at 23/24 and 230/231, the sub-case boundaries at 25/26, 1/2 and 252/253, the special-case priority, the signalling-bit rule for invalid, and the normalisation of subnormal operands.

// File: rtl/divpre_pkg.sv
package divpre_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int LZ_W  = $clog2(MAN_W + 1);
  localparam int SE_W  = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [FP_W-1:0]  NAN_ALL = '1;
  localparam logic [FP_W-1:0]  FP_ONE  = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  typedef enum logic [7:0] {
    ADJ_NONE  = 8'h00,
    ADJ_OVER  = 8'h40,
    ADJ_UNDER = 8'h80
  } adj_e;

  typedef struct packed {
    logic             nan;
    logic             inf;
    logic             zero;
    logic             sign;
    logic             quiet;
    logic [EXP_W-1:0] eexp;
  } opclass_t;

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [MAN_W-1:0] m);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (m[i]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction
endpackage

// File: rtl/divpre_classify.sv
module divpre_classify
  import divpre_pkg::*;
(
  input  logic [FP_W-1:0] val,
  output opclass_t        cls
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;

  assign ex  = val[FP_W-2 -: EXP_W];
  assign man = val[MAN_W-1:0];

  always_comb begin
    cls.sign  = val[FP_W-1];
    cls.nan   = (ex == EXP_MAX) && (man != '0);
    cls.inf   = (ex == EXP_MAX) && (man == '0);
    cls.zero  = (ex == '0) && (man == '0);
    cls.quiet = man[MAN_W-1];
    cls.eexp  = (ex == '0) ? EXP_W'(1) : ex;
  end
endmodule

// File: rtl/divpre_scale.sv
module divpre_scale
  import divpre_pkg::*;
(
  input  logic [FP_W-1:0]   val,
  input  logic signed [7:0] shamt,
  output logic [FP_W-1:0]   res
);
  logic                   sgn;
  logic [EXP_W-1:0]       ex;
  logic [MAN_W-1:0]       man, frac;
  logic [LZ_W-1:0]        lz;
  logic signed [SE_W-1:0] e_in, e_out, sh_ext, sub_sh;
  logic [MAN_W:0]         full, sub_m;

  assign sgn = val[FP_W-1];
  assign ex  = val[FP_W-2 -: EXP_W];
  assign man = val[MAN_W-1:0];
  assign lz  = lead_zeros(man);

  always_comb begin
    sh_ext = {{(SE_W-8){shamt[7]}}, shamt};
    if (ex == '0) begin
      e_in = -$signed({{(SE_W-LZ_W){1'b0}}, lz});
      frac = man << (lz + 1'b1);
    end else begin
      e_in = $signed({2'b00, ex});
      frac = man;
    end
    e_out  = e_in + sh_ext;
    full   = {1'b1, frac};
    sub_sh = SE_W'(1) - e_out;
    sub_m  = '0;
    if (sub_sh <= SE_W'(MAN_W + 1)) sub_m = full >> sub_sh[LZ_W-1:0];

    if (shamt == '0 || ex == EXP_MAX || (ex == '0 && man == '0))
      res = val;
    else if (e_out >= $signed(SE_W'(EXP_MAX)))
      res = {sgn, EXP_MAX, {MAN_W{1'b0}}};
    else if (e_out >= SE_W'(1))
      res = {sgn, e_out[EXP_W-1:0], frac};
    else
      res = {sgn, {EXP_W{1'b0}}, sub_m[MAN_W-1:0]};
  end
endmodule

// File: rtl/divpre_fixup.sv
module divpre_fixup
  import divpre_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [FP_W-1:0] num_in,
  input  logic [FP_W-1:0] den_in,
  output logic            out_valid,
  output logic [FP_W-1:0] num_out,
  output logic [FP_W-1:0] den_out,
  output logic [FP_W-1:0] seed_out,
  output logic [7:0]      adj_code,
  output logic            proceed,
  output logic [1:0]      exc_flags
);
  localparam int NOPS = 2;

  logic                 v1;
  logic [FP_W-1:0]      ops    [NOPS];
  logic [FP_W-1:0]      scaled [NOPS];
  opclass_t             cls    [NOPS];
  logic signed [7:0]    shv    [NOPS];
  logic signed [SE_W:0] diff;
  logic                 sx, ordinary;
  adj_e                 adj_nx;
  logic [FP_W-1:0]      n_nx, d_nx, s_nx;
  logic [1:0]           fl_nx;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      ops[0] <= '0;
      ops[1] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        ops[0] <= num_in;
        ops[1] <= den_in;
      end
    end
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    divpre_classify u_cls (.val(ops[g]), .cls(cls[g]));
    divpre_scale    u_scl (.val(ops[g]), .shamt(shv[g]), .res(scaled[g]));
  end

  assign sx       = cls[0].sign ^ cls[1].sign;
  assign ordinary = !(cls[0].nan | cls[1].nan | cls[0].inf | cls[1].inf |
                      cls[0].zero | cls[1].zero);
  assign diff     = $signed({3'b000, cls[0].eexp}) - $signed({3'b000, cls[1].eexp}) + 11'sd127;

  // scaling decision for ordinary operands
  always_comb begin
    adj_nx = ADJ_NONE;
    shv[0] = 8'sd0;
    shv[1] = 8'sd0;
    if (ordinary) begin
      if (diff <= 11'sd23) begin
        adj_nx = ADJ_UNDER;  shv[0] = 8'sd64;  shv[1] = -8'sd64;
      end else if (diff > 11'sd230) begin
        adj_nx = ADJ_OVER;   shv[0] = -8'sd32; shv[1] = 8'sd32;
      end else if (cls[0].eexp <= 8'd25) begin
        shv[0] = 8'sd64;  shv[1] = 8'sd64;
      end else if (cls[1].eexp <= 8'd1) begin
        shv[0] = 8'sd32;  shv[1] = 8'sd32;
      end else if (cls[1].eexp > 8'd252) begin
        shv[0] = -8'sd32; shv[1] = -8'sd32;
      end
    end
  end

  // special-case substitution in priority order
  always_comb begin
    n_nx  = scaled[0];
    d_nx  = scaled[1];
    s_nx  = '0;
    fl_nx = 2'b00;
    if (cls[0].nan || cls[1].nan) begin
      n_nx = NAN_ALL; d_nx = NAN_ALL; s_nx = NAN_ALL;
      fl_nx[0] = (cls[0].nan && !cls[0].quiet) || (cls[1].nan && !cls[1].quiet);
    end else if ((cls[0].inf && cls[1].inf) || (cls[0].zero && cls[1].zero)) begin
      n_nx = NAN_ALL; d_nx = NAN_ALL; s_nx = NAN_ALL;
      fl_nx[0] = 1'b1;
    end else if (cls[1].zero) begin
      n_nx = {sx, EXP_MAX, {MAN_W{1'b0}}}; d_nx = FP_ONE; s_nx = FP_ONE;
      fl_nx[1] = 1'b1;
    end else if (cls[1].inf || cls[0].zero) begin
      n_nx = {sx, {(FP_W-1){1'b0}}}; d_nx = FP_ONE; s_nx = FP_ONE;
    end else if (cls[0].inf) begin
      n_nx = {sx, EXP_MAX, {MAN_W{1'b0}}}; d_nx = FP_ONE; s_nx = FP_ONE;
    end
  end

  // stage 2: result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      num_out   <= '0;
      den_out   <= '0;
      seed_out  <= '0;
      adj_code  <= '0;
      proceed   <= 1'b0;
      exc_flags <= '0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        num_out   <= n_nx;
        den_out   <= d_nx;
        seed_out  <= s_nx;
        adj_code  <= adj_nx;
        proceed   <= ordinary;
        exc_flags <= fl_nx;
      end
    end
  end
endmodule

// File: rtl/divpre_fixup_chk.sv
module divpre_fixup_chk
  import divpre_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [FP_W-1:0] num_out,
  input logic [FP_W-1:0] den_out,
  input logic [FP_W-1:0] seed_out,
  input logic [7:0]      adj_code,
  input logic            proceed,
  input logic [1:0]      exc_flags
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)               age <= '0;
    else if (age != 2'd2)  age <= age + 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_valid) |->
      ($stable(num_out) && $stable(den_out) && $stable(seed_out) &&
       $stable(adj_code) && $stable(proceed) && $stable(exc_flags)));

  p_go_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && proceed) |-> (seed_out == '0 && exc_flags == 2'b00));

  p_adj_legal_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((adj_code == 8'h00 || adj_code == 8'h40 || adj_code == 8'h80) &&
                   (proceed || adj_code == 8'h00)));

  p_invalid_nan_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_flags[0]) |->
      (num_out == NAN_ALL && den_out == NAN_ALL && seed_out == NAN_ALL && !proceed));

  p_dbz_inf_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_flags[1]) |->
      (num_out[FP_W-2:0] == {EXP_MAX, {MAN_W{1'b0}}} && den_out == FP_ONE && seed_out == FP_ONE));
endmodule

bind divpre_fixup divpre_fixup_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .num_out(num_out), .den_out(den_out), .seed_out(seed_out),
  .adj_code(adj_code), .proceed(proceed), .exc_flags(exc_flags)
);

// File: tb/divpre_fixup_tb_top.sv
`timescale 1ns/1ps
module divpre_fixup_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] num_in, den_in;
  logic        out_valid;
  logic [31:0] num_out, den_out, seed_out;
  logic [7:0]  adj_code;
  logic        proceed;
  logic [1:0]  exc_flags;

  always #2.5 clk = ~clk;

  divpre_fixup dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .num_in(num_in), .den_in(den_in),
    .out_valid(out_valid), .num_out(num_out), .den_out(den_out), .seed_out(seed_out),
    .adj_code(adj_code), .proceed(proceed), .exc_flags(exc_flags)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // model expectation (held between results)
  logic [31:0] e_n = 0, e_d = 0, e_s = 0;
  logic [7:0]  e_adj = 0;
  logic        e_go = 0;
  logic [1:0]  e_fl = 0;
  string       e_tag = "R12";
  // stimulus history: slot 1 = last cycle, slot 2 = two cycles ago
  bit          p1_v = 0, p2_v = 0;
  logic [31:0] p1_a = 0, p1_b = 0, p2_a = 0, p2_b = 0;

  function automatic bit f_nan(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] != 0; endfunction
  function automatic bit f_inf(input logic [31:0] x);  return x[30:23] == 8'hFF && x[22:0] == 0; endfunction
  function automatic bit f_zero(input logic [31:0] x); return x[30:0] == 0; endfunction
  function automatic int f_eexp(input logic [31:0] x); return (x[30:23] == 0) ? 1 : int'(x[30:23]); endfunction

  // exact power-of-two scaling by integer significand arithmetic
  function automatic logic [31:0] f_scale(input logic [31:0] x, input int k);
    int e;
    logic [23:0] m;
    if (k == 0) return x;
    if (x[30:23] == 0) begin
      e = 1;
      m = {1'b0, x[22:0]};
      while (!m[23]) begin m = m << 1; e = e - 1; end
    end else begin
      e = int'(x[30:23]);
      m = {1'b1, x[22:0]};
    end
    e = e + k;
    return {x[31], 8'(e), m[22:0]};
  endfunction

  task automatic ref_model(input logic [31:0] a, input logic [31:0] b);
    bit sx = a[31] ^ b[31];
    int d, ne, de;
    e_s = 32'h3F80_0000; e_adj = 8'h00; e_go = 0; e_fl = 2'b00; e_d = 32'h3F80_0000;
    if (f_nan(a) || f_nan(b)) begin
      e_n = '1; e_d = '1; e_s = '1;
      e_fl[0] = (f_nan(a) && !a[22]) || (f_nan(b) && !b[22]);
      e_tag = "R2 R6 R10";
    end else if ((f_inf(a) && f_inf(b)) || (f_zero(a) && f_zero(b))) begin
      e_n = '1; e_d = '1; e_s = '1; e_fl[0] = 1; e_tag = "R3 R6 R10";
    end else if (f_zero(b)) begin
      e_n = {sx, 8'hFF, 23'd0}; e_fl[1] = 1; e_tag = "R4 R6 R10";
    end else if (f_inf(b) || f_zero(a)) begin
      e_n = {sx, 31'd0}; e_tag = "R5 R6 R10";
    end else if (f_inf(a)) begin
      e_n = {sx, 8'hFF, 23'd0}; e_tag = "R5 R6 R10";
    end else begin
      ne = f_eexp(a); de = f_eexp(b); d = ne - de + 127;
      e_go = 1; e_s = 0;
      if (d <= 23) begin
        e_adj = 8'h80; e_n = f_scale(a, 64); e_d = f_scale(b, -64); e_tag = "R7 R10";
      end else if (d > 230) begin
        e_adj = 8'h40; e_n = f_scale(a, -32); e_d = f_scale(b, 32); e_tag = "R8 R10";
      end else if (ne <= 25) begin
        e_n = f_scale(a, 64); e_d = f_scale(b, 64); e_tag = "R9 R10";
      end else if (de <= 1) begin
        e_n = f_scale(a, 32); e_d = f_scale(b, 32); e_tag = "R9 R10";
      end else if (de > 252) begin
        e_n = f_scale(a, -32); e_d = f_scale(b, -32); e_tag = "R9 R10";
      end else begin
        e_n = a; e_d = b; e_tag = "R9 R10";
      end
      if (a[30:23] == 0 || b[30:23] == 0) e_tag = {e_tag, " R11"};
    end
  endtask

  task automatic compare();
    if (p2_v) ref_model(p2_a, p2_b);
    else if (e_tag != "R12") e_tag = "R1";
    checks++;
    if (out_valid !== p2_v || num_out !== e_n || den_out !== e_d || seed_out !== e_s ||
        adj_code !== e_adj || proceed !== e_go || exc_flags !== e_fl) begin
      fails++;
      $display("FAIL %s: got v=%0b n=%h d=%h s=%h adj=%h go=%0b fl=%b, expected v=%0b n=%h d=%h s=%h adj=%h go=%0b fl=%b",
               e_tag, out_valid, num_out, den_out, seed_out, adj_code, proceed, exc_flags,
               p2_v, e_n, e_d, e_s, e_adj, e_go, e_fl);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    compare();
    p2_v = p1_v; p2_a = p1_a; p2_b = p1_b;
    p1_v = v;    p1_a = a;    p1_b = b;
    in_valid = v; num_in = a; den_in = b;
  endtask

  function automatic logic [31:0] mk(input bit s, input int e, input logic [22:0] m);
    return {s, 8'(e), m};
  endfunction

  function automatic logic [31:0] rnd_op();
    logic [31:0] r = $urandom;
    case ($urandom % 9)
      0: return {r[31], 31'd0};
      1: return {r[31], 8'hFF, 23'd0};
      2: return {r[31], 8'hFF, r[22:1], 1'b1};
      3: return {r[31], 8'h00, r[22:1], 1'b1};
      4: return {r[31], 8'(1 + ($urandom % 30)), r[22:0]};
      5: return {r[31], 8'(224 + ($urandom % 31)), r[22:0]};
      default: return {r[31], 8'(1 + ($urandom % 254)), r[22:0]};
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    rst = 1; in_valid = 0; num_in = 0; den_in = 0;
    repeat (3) @(negedge clk);
    // R12: reset state is checked by the first steps (expectations all zero)
    rst = 0;
    step(0, 32'hDEAD_BEEF, 32'h1234_5678);   // R1: ignored without valid
    step(0, 32'h3F80_0000, 32'h0000_0000);
    // R2: NaN handling and signalling bit
    step(1, 32'h7FC0_0000, 32'h3F80_0000);
    step(1, 32'h7F80_0001, 32'h3F80_0000);
    step(1, 32'h3F80_0000, 32'hFFA0_0000);
    step(1, 32'h7FC0_0001, 32'h7FC0_0000);
    step(1, 32'h7FC0_0000, 32'h7F80_0001);
    // R6: NaN outranks zero/inf cases
    step(1, 32'h7F80_0001, 32'h0000_0000);
    // R3
    step(1, 32'h7F80_0000, 32'hFF80_0000);
    step(1, 32'h8000_0000, 32'h0000_0000);
    // R4 (incl. infinite numerator, R6 order)
    step(1, 32'hC040_0000, 32'h0000_0000);
    step(1, 32'h7F80_0000, 32'h8000_0000);
    step(1, 32'h0000_0001, 32'h0000_0000);
    // R5 and R6: zero over inf -> zero, inf over finite -> inf
    step(1, 32'h3F80_0000, 32'hFF80_0000);
    step(1, 32'h0000_0000, 32'hFF80_0000);
    step(1, 32'h8000_0000, 32'h4000_0000);
    step(1, 32'hFF80_0000, 32'h4000_0000);
    // R7/R9 threshold 23/24, R8 threshold 230/231
    step(1, mk(0, 20, 23'h12345), mk(1, 124, 23'h7));
    step(1, mk(0, 21, 23'h12345), mk(1, 124, 23'h7));
    step(1, mk(1, 200, 23'h1), mk(0, 97, 23'h55));
    step(1, mk(1, 201, 23'h1), mk(0, 97, 23'h55));
    // R9 sub-case boundaries
    step(1, mk(0, 25, 23'h3), mk(0, 20, 23'h9));
    step(1, mk(0, 26, 23'h3), mk(0, 20, 23'h9));
    step(1, mk(0, 100, 23'h3), mk(0, 1, 23'h9));
    step(1, mk(0, 100, 23'h3), mk(0, 2, 23'h9));
    step(1, mk(0, 200, 23'h3), mk(0, 252, 23'h9));
    step(1, mk(0, 200, 23'h3), mk(0, 253, 23'h9));
    // R11: subnormal operands
    step(1, 32'h0000_0001, 32'h3F80_0000);
    step(1, 32'h4000_0000, 32'h8040_0000);
    step(1, 32'h7F00_0000, 32'h0000_0003);
    // R1: back-to-back then gaps
    for (int i = 0; i < 400; i++) step(($urandom % 4) != 0, rnd_op(), rnd_op());
    for (int i = 0; i < 4; i++) step(0, $urandom, $urandom);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1: watchdog expired, got no end, expected completion");
    summary();
  end
endmodule